// File: doc/BRIEF.md
# Operand Preparation Stage with Banked Addressing and Register Redirection

This block sits between instruction decode and execute in an 8-bit accumulator processor whose data memory is split into 256-byte banks. Each decoded instruction brings an 8-bit file address, an addressing-mode bit, a destination bit, a bit-operation flag and a 3-bit bit index. The block turns the file address into a 12-bit data-memory address. In banked mode it puts the 4-bit bank register in front of the file address. In fixed mode it uses a split window: the low half of bank 0 and the high half of bank 15.

A small set of 12-bit addresses names the processor's own registers: the working register, the flag register, the bank register and the stack pointer. A reference to one of these addresses is served from that register's current value, and no data-memory read is issued. Any other address is read from data memory through a port with a combinational read path.

The block then registers one result for the execute stage. The result holds source 1, source 2, the carry flag and a destination descriptor. Source 2 is either the working register or a one-hot bit mask.

Both streams use a valid/ready handshake. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed on at an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every result field holds still and `in_ready` is low. The result register can be refilled in the same cycle it is drained, so `in_ready` follows `out_ready` combinationally and the stream keeps one transfer per clock.

Top module: `ofs_operand_stage`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `mem_rd_en` is 0.
- R2: With `in_banked`=1 the formed address is {`bank_sel`, `in_faddr`}. It appears on `mem_addr` during the accept cycle and on `out_dst_addr` with the result.
- R3: With `in_banked`=0, file addresses 0x00..0x7F form 0x000..0x07F and file addresses 0x80..0xFF form 0xF80..0xFFF.
- R4: The formed addresses 0xFE8, 0xFD8, 0xFE0 and 0xFFC map to the working register, the flag register, the bank register (zero-extended) and the stack pointer. For these, source 1 is that register's value, `mem_rd_en` stays 0 in the accept cycle, `out_dst_mapped` is 1 and `out_dst_reg` is 0, 1, 2 or 3 respectively. This applies in either addressing mode.
- R5: For any other formed address, `mem_rd_en` is 1 exactly in the accept cycle, source 1 is the `mem_rdata` value of that cycle, and `out_dst_mapped` is 0.
- R6: With `in_bitop`=0 source 2 is the working register. With `in_bitop`=1 source 2 is a mask with only bit `in_bitsel` set.
- R7: `out_dst_wreg` is 1 when `in_dest` was 0 (the result goes to the working register) and 0 when `in_dest` was 1 (the result goes to the addressed location).
- R8: `out_carry` is the value of the carry input in the accept cycle.
- R9: While `out_valid` is high and `out_ready` is low, all result fields stay unchanged and `in_ready` is 0. Results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Stage can take an instruction |
| in_faddr | input | 8 | File address from instruction |
| in_banked | input | 1 | 1 = use bank register, 0 = split fixed window |
| in_dest | input | 1 | 0 = result to working register, 1 = to file |
| in_bitop | input | 1 | 1 = bit-oriented instruction |
| in_bitsel | input | 3 | Bit index for bit-oriented instructions |
| wreg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank register value |
| carry | input | 1 | Carry flag |
| status | input | 8 | Flag register value |
| stkptr | input | 8 | Stack pointer value |
| mem_rd_en | output | 1 | Data-memory read strobe |
| mem_addr | output | 12 | Formed data-memory address |
| mem_rdata | input | 8 | Data-memory read data (same cycle) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Execute stage takes result |
| out_src1 | output | 8 | Source 1 operand |
| out_src2 | output | 8 | Source 2 operand (working register or bit mask) |
| out_carry | output | 1 | Carry for rotate-through-carry |
| out_dst_wreg | output | 1 | Result goes to working register |
| out_dst_addr | output | 12 | Formed address of the file target |
| out_dst_mapped | output | 1 | File target is a dedicated register |
| out_dst_reg | output | 2 | Dedicated register index |

## Verification
Fixed-mode addresses on both sides of the 0x7F/0x80 split show whether the window picks bank 0 or bank 15 correctly. Banked addresses with several bank values show whether the bank register is really prepended.

Each dedicated-register address is sent in fixed mode and again in banked mode with bank 15. The same low byte is also sent with bank 0. Together these show that redirection follows the full formed address, not the file byte alone.

Every bit index is sent with the bit-operation flag set, and both destination values are sent. A long pseudo-random stream under random `out_ready` stalls shows that stall holding and in-order delivery work.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int NSREG = 4;
  localparam int SREG_IW = $clog2(NSREG);

  typedef enum logic [SREG_IW-1:0] {
    SR_WORK  = 2'd0,
    SR_FLAGS = 2'd1,
    SR_BANK  = 2'd2,
    SR_STACK = 2'd3
  } sreg_e;
endpackage

// File: rtl/ofs_addr_gen.sv
module ofs_addr_gen #(
  parameter int FW  = 8,
  parameter int BKW = 4,
  localparam int AW = FW + BKW
) (
  input  logic [FW-1:0]  faddr,
  input  logic           banked,
  input  logic [BKW-1:0] bank,
  output logic [AW-1:0]  addr
);
  // fixed window: top file bit picks first or last bank
  logic [BKW-1:0] fixed_bank;

  assign fixed_bank = {BKW{faddr[FW-1]}};

  always_comb begin
    if (banked) addr = {bank, faddr};
    else        addr = {fixed_bank, faddr};
  end
endmodule

// File: rtl/ofs_reg_map.sv
module ofs_reg_map
  import ofs_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int N  = NSREG
) (
  input  logic [AW-1:0]        addr,
  input  logic [N-1:0][AW-1:0] map_addr,
  input  logic [N-1:0][DW-1:0] map_val,
  output logic                 hit,
  output logic [SREG_IW-1:0]   idx,
  output logic [DW-1:0]        val
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = (addr == map_addr[g]);
  end

  assign hit = |hit_vec;

  always_comb begin
    idx = '0;
    val = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        idx = SREG_IW'(i);
        val = map_val[i];
      end
    end
  end
endmodule

// File: rtl/ofs_src2_sel.sv
module ofs_src2_sel #(
  parameter int DW = 8,
  localparam int BITW = $clog2(DW)
) (
  input  logic            bitop,
  input  logic [BITW-1:0] bitsel,
  input  logic [DW-1:0]   wreg,
  output logic [DW-1:0]   src2
);
  logic [DW-1:0] mask;

  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (bitsel == BITW'(g));
  end

  assign src2 = bitop ? mask : wreg;
endmodule

// File: rtl/ofs_operand_stage.sv
module ofs_operand_stage
  import ofs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int FW  = 8,
  parameter int BKW = 4,
  localparam int AW   = FW + BKW,
  localparam int BITW = $clog2(DW),
  parameter logic [AW-1:0] A_WORK  = 12'hFE8,
  parameter logic [AW-1:0] A_FLAGS = 12'hFD8,
  parameter logic [AW-1:0] A_BANK  = 12'hFE0,
  parameter logic [AW-1:0] A_STACK = 12'hFFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FW-1:0]      in_faddr,
  input  logic               in_banked,
  input  logic               in_dest,
  input  logic               in_bitop,
  input  logic [BITW-1:0]    in_bitsel,
  input  logic [DW-1:0]      wreg,
  input  logic [BKW-1:0]     bank_sel,
  input  logic               carry,
  input  logic [DW-1:0]      status,
  input  logic [DW-1:0]      stkptr,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW-1:0]      out_src1,
  output logic [DW-1:0]      out_src2,
  output logic               out_carry,
  output logic               out_dst_wreg,
  output logic [AW-1:0]      out_dst_addr,
  output logic               out_dst_mapped,
  output logic [SREG_IW-1:0] out_dst_reg
);
  logic [AW-1:0]              f_addr;
  logic                       m_hit;
  logic [SREG_IW-1:0]         m_idx;
  logic [DW-1:0]              m_val;
  logic [DW-1:0]              src2_c;
  logic [DW-1:0]              src1_c;
  logic                       accept;
  logic [NSREG-1:0][AW-1:0]   map_addr;
  logic [NSREG-1:0][DW-1:0]   map_val;

  assign map_addr[SR_WORK]  = A_WORK;
  assign map_addr[SR_FLAGS] = A_FLAGS;
  assign map_addr[SR_BANK]  = A_BANK;
  assign map_addr[SR_STACK] = A_STACK;

  assign map_val[SR_WORK]  = wreg;
  assign map_val[SR_FLAGS] = status;
  assign map_val[SR_BANK]  = {{(DW-BKW){1'b0}}, bank_sel};
  assign map_val[SR_STACK] = stkptr;

  ofs_addr_gen #(.FW(FW), .BKW(BKW)) u_addr (
    .faddr  (in_faddr),
    .banked (in_banked),
    .bank   (bank_sel),
    .addr   (f_addr)
  );

  ofs_reg_map #(.AW(AW), .DW(DW), .N(NSREG)) u_map (
    .addr     (f_addr),
    .map_addr (map_addr),
    .map_val  (map_val),
    .hit      (m_hit),
    .idx      (m_idx),
    .val      (m_val)
  );

  ofs_src2_sel #(.DW(DW)) u_src2 (
    .bitop  (in_bitop),
    .bitsel (in_bitsel),
    .wreg   (wreg),
    .src2   (src2_c)
  );

  // one result slot; refilled in the same cycle it drains
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign mem_addr  = f_addr;
  assign mem_rd_en = accept && !m_hit;
  assign src1_c    = m_hit ? m_val : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_src1       <= '0;
      out_src2       <= '0;
      out_carry      <= 1'b0;
      out_dst_wreg   <= 1'b0;
      out_dst_addr   <= '0;
      out_dst_mapped <= 1'b0;
      out_dst_reg    <= '0;
    end else if (accept) begin
      out_src1       <= src1_c;
      out_src2       <= src2_c;
      out_carry      <= carry;
      out_dst_wreg   <= !in_dest;
      out_dst_addr   <= f_addr;
      out_dst_mapped <= m_hit;
      out_dst_reg    <= m_idx;
    end
  end
endmodule

// File: rtl/ofs_operand_stage_chk.sv
module ofs_operand_stage_chk #(
  parameter int DW  = 8,
  parameter int FW  = 8,
  parameter int BKW = 4,
  localparam int AW = FW + BKW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [FW-1:0] in_faddr,
  input logic          in_banked,
  input logic          in_dest,
  input logic          in_bitop,
  input logic [BKW-1:0] bank_sel,
  input logic          carry,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_src1,
  input logic [DW-1:0] out_src2,
  input logic          out_carry,
  input logic          out_dst_wreg,
  input logic [AW-1:0] out_dst_addr,
  input logic          out_dst_mapped
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_banked_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && in_banked |-> mem_addr == {bank_sel, in_faddr});

  p_fixed_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !in_banked |->
      mem_addr == {{BKW{in_faddr[FW-1]}}, in_faddr});

  p_mapped_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mem_rd_en |=> out_dst_mapped);

  p_mem_only_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> acc);

  p_mem_not_mapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !out_dst_mapped);

  p_mask_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_bitop |=> $countones(out_src2) == 1);

  p_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_dst_wreg == !$past(in_dest) && out_dst_addr == $past(mem_addr));

  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_carry == $past(carry));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src1) &&
      $stable(out_src2) && $stable(out_dst_addr) && $stable(out_carry));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind ofs_operand_stage ofs_operand_stage_chk #(.DW(DW), .FW(FW), .BKW(BKW)) u_chk (.*);

// File: tb/ofs_operand_stage_bench.sv
`timescale 1ns/1ps
module ofs_operand_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_faddr = '0;
  logic        in_banked = 1'b0;
  logic        in_dest = 1'b0;
  logic        in_bitop = 1'b0;
  logic [2:0]  in_bitsel = '0;
  logic [7:0]  wreg = 8'h3C;
  logic [3:0]  bank_sel = 4'h0;
  logic        carry = 1'b0;
  logic [7:0]  status = 8'h81;
  logic [7:0]  stkptr = 8'h07;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_src1;
  logic [7:0]  out_src2;
  logic        out_carry;
  logic        out_dst_wreg;
  logic [11:0] out_dst_addr;
  logic        out_dst_mapped;
  logic [1:0]  out_dst_reg;

  int errors = 0;
  int checks = 0;
  bit bp_on = 1'b0;
  logic [15:0] bp_lfsr = 16'hACE1;
  logic [31:0] seed = 32'h1234_5678;
  logic [32:0] exp_q[$];

  always #2 clk = ~clk;

  ofs_operand_stage u_ofs_operand_stage (.*);

  // memory model: combinational read, distinct per bank
  assign mem_rdata = mem_addr[7:0] ^ {mem_addr[11:8], mem_addr[11:8]} ^ 8'h5A;

  function automatic logic [7:0] mem_val(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [32:0] act,
                     input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bp_lfsr <= {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
    out_ready <= bp_on ? bp_lfsr[0] : 1'b1;
  end

  task automatic send(input logic [7:0] f, input bit b, input bit d,
                      input logic [2:0] bs, input bit bo);
    logic [11:0] ea;
    bit          mp;
    logic [1:0]  ri;
    logic [7:0]  s1, s2;
    bit          done;
    @(negedge clk);
    in_faddr = f; in_banked = b; in_dest = d; in_bitsel = bs; in_bitop = bo;
    in_valid = 1'b1;
    done = 1'b0;
    while (!done) begin
      #1;
      if (in_ready) begin
        ea = b ? {bank_sel, f} : {{4{f[7]}}, f};
        mp = 1'b1; ri = 2'd0;
        case (ea)
          12'hFE8: begin ri = 2'd0; s1 = wreg; end
          12'hFD8: begin ri = 2'd1; s1 = status; end
          12'hFE0: begin ri = 2'd2; s1 = {4'h0, bank_sel}; end
          12'hFFC: begin ri = 2'd3; s1 = stkptr; end
          default: begin mp = 1'b0; s1 = mem_val(ea); end
        endcase
        s2 = bo ? (8'h01 << bs) : wreg;
        chk(mem_addr == ea, b ? "R2 mem_addr" : "R3 mem_addr",
            33'(mem_addr), 33'(ea));
        chk(mem_rd_en == !mp, mp ? "R4 mem_rd_en" : "R5 mem_rd_en",
            33'(mem_rd_en), 33'(!mp));
        exp_q.push_back({s1, s2, carry, !d, ea, mp, ri});
        @(posedge clk);
        #0.5 in_valid = 1'b0;
        done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  // monitor: compare transfers, watch stall holding
  logic [32:0] held;
  bit          was_stalled = 1'b0;
  always @(negedge clk) begin
    logic [32:0] act;
    logic [32:0] e;
    #1;
    act = {out_src1, out_src2, out_carry, out_dst_wreg, out_dst_addr,
           out_dst_mapped, out_dst_reg};
    if (rst_n) begin
      if (was_stalled)
        chk(out_valid && act == held, "R9 held result", act, held);
      if (out_valid && !out_ready)
        chk(!in_ready, "R9 in_ready low on stall", 33'(in_ready), 33'(0));
      was_stalled = out_valid && !out_ready;
      held = act;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", act, '0);
        end else begin
          e = exp_q.pop_front();
          chk(act[32:25] == e[32:25], e[2] ? "R4 src1" : "R5 src1", act, e);
          chk(act[24:17] == e[24:17], "R6 src2", act, e);
          chk(act[16] == e[16], "R8 carry", act, e);
          chk(act[15] == e[15], "R7 dst_wreg", act, e);
          chk(act[14:0] == e[14:0], "R4 dst addr/mapped/index", act, e);
        end
      end
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready && !mem_rd_en, "R1 reset state",
        33'({out_valid, in_ready, mem_rd_en}), 33'(3'b010));
    @(negedge clk);
    rst_n = 1'b1;

    bank_sel = 4'h3; send(8'h45, 1, 1, 0, 0);          // R2
    bank_sel = 4'hA; send(8'h80, 1, 0, 0, 0);          // R2
    send(8'h12, 0, 0, 0, 0);                           // R3 low
    send(8'h7F, 0, 1, 0, 0);                           // R3 edge
    send(8'h80, 0, 1, 0, 0);                           // R3 edge
    send(8'h90, 0, 0, 0, 0);                           // R3 high
    carry = 1'b1;
    send(8'hE8, 0, 0, 0, 0);                           // R4 work
    send(8'hD8, 0, 1, 0, 0);                           // R4 flags
    send(8'hE0, 0, 1, 0, 0);                           // R4 bank
    send(8'hFC, 0, 1, 0, 0);                           // R4 stack
    bank_sel = 4'hF; send(8'hE8, 1, 1, 0, 0);          // R4 banked hit
    bank_sel = 4'h0; send(8'hE8, 1, 1, 0, 0);          // R5 not a hit
    carry = 1'b0;
    for (int i = 0; i < 8; i++) send(8'h20, 0, 1, 3'(i), 1);  // R6 masks

    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      seed = nxt(seed);
      bank_sel = seed[15:12];
      carry = seed[16];
      wreg = seed[31:24];
      if (seed[20:18] == 3'd0) send({seed[17], seed[17], 1'b1, 1'b0, seed[17], 3'b000}, 0, seed[5], seed[10:8], seed[9]);
      else send(seed[7:0], seed[4], seed[5], seed[10:8], seed[9]);
    end
    bp_on = 1'b0;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 33'(exp_q.size()), 33'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule